// File: doc/BRIEF.md
# Multi-Buffer DMA Channel Controller with Address Reload

This block copies a series of equal-length buffers from a source region to a destination region, one word at a time. It has a small number of channels, and they share a single-beat memory master port. Software programs each channel with a start source address, a start destination address, a word count and an automatic-mode bit, then sets the channel's enable bit. The channel's enable flag stays high for the whole multi-buffer transfer, so software can poll it to find the end.

Each buffer starts again from the programmed source and destination addresses. When a buffer ends, the channel's per-channel interrupt mask bit decides what happens next. If the bit is unmasked, the channel raises a pending interrupt and stalls until software writes its keep-on bit. If the bit is masked, the channel starts the next buffer at once. While the automatic-mode bit is clear, the buffer in progress is the last one, and the channel disables itself when that buffer completes.

When more than one channel is ready, a fixed-priority choice is made at every word boundary. The memory port performs one read and then one write per word, and each access waits for `mem_ready`.

Top module: `multibuf_dma`

## Requirements
- R1: After reset all enable and stall flags are 0, `irq` is 0, `mem_valid` is 0 and the pending register reads 0.
- R2: Writing 1 to bit n at offset 0 starts channel n only if it is not already enabled. Its enable flag then stays 1 until its final buffer completes. A start written to an enabled channel has no effect.
- R3: Word k of every buffer is read from source base + k and written to destination base + k. The write carries the data just read. With automatic mode set, each new buffer begins again at the programmed bases.
- R4: While the automatic-mode bit is 0, the channel clears its enable flag in the cycle after the last word of the current buffer is written.
- R5: When a buffer ends on a channel whose mask bit is 1 (unmasked) and whose automatic mode is on, the channel's stall flag sets. No memory access is made for that channel while the flag is set.
- R6: Writing 1 to bit n at offset 1 (keep-on) clears channel n's stall flag, and the next buffer begins. A keep-on to a channel that is not stalled changes nothing.
- R7: A channel whose mask bit is 0 never stalls. It starts the next buffer right after the previous one.
- R8: A programmed word count of 0 moves exactly one word per buffer.
- R9: Every buffer end sets the channel's pending bit. A read of offset 3 returns the pending bits and clears them. `irq` is 1 exactly when some pending bit has its mask bit set to 1.
- R10: Each word is a read access followed by a write access (`mem_write` = 1). `mem_valid`, `mem_write` and `mem_addr` hold steady until `mem_ready` is seen, and the port returns to idle for one cycle after each write.
- R11: At every word boundary the lowest-numbered channel that is enabled and not stalled is served.
- R12: Register offsets are as follows:
  - Offset 0 reads the enable flags in bits [NCH-1:0] and the stall flags in bits [2*NCH-1:NCH].
  - Offset 2 holds the mask, where 1 means unmasked.
  - Channel n's fields sit at offset 4+4n+f, where f = 0 is the source base, f = 1 the destination base, f = 2 the word count and f = 3 the automatic-mode bit (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (read of offset 3 clears pending) |
| reg_addr | input | RAW | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| irq | output | 1 | Unmasked buffer-complete interrupt |
| stat_en | output | NCH | Per-channel enable flags |
| stat_stall | output | NCH | Per-channel stall flags |

## Verification
The following properties are checked on every cycle:
- a stall can only appear after an unmasked buffer end in automatic mode;
- an enable flag can only fall after the last word of a non-automatic buffer;
- no word completes for a stalled channel;
- every buffer end leaves its pending bit set;
- at most one channel completes a word at a time;
- the memory request holds steady until it is accepted.

Some behaviour can only be shown by the bench scenarios. These are the address reload across several buffers, the stall-and-resume sequence driven by keep-on writes, the start that is ignored on a busy channel, the one-word buffer, clear-on-read of the pending register and the order in which two channels started together are served.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_WR   = 2'd2
  } mv_state_e;

  // Register offsets
  localparam int REG_ENABLE   = 0;
  localparam int REG_KEEPON   = 1;
  localparam int REG_MASK     = 2;
  localparam int REG_PEND     = 3;
  localparam int REG_CFG_BASE = 4;
  localparam int CFG_STRIDE   = 4;

  // Per-channel field selectors
  localparam int CFG_SRC  = 0;
  localparam int CFG_DST  = 1;
  localparam int CFG_LEN  = 2;
  localparam int CFG_AUTO = 3;

  function automatic logic [31:0] cfg_addr(input int ch, input int field);
    return 32'(REG_CFG_BASE + ch * CFG_STRIDE + field);
  endfunction

  // A zero count behaves as a one-word buffer.
  function automatic logic last_word(input logic [31:0] idx, input logic [31:0] len);
    return (len == 32'd0) || (idx + 32'd1 >= len);
  endfunction

endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // Lowest set bit wins.
  assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_we,
  input  logic          dst_we,
  input  logic          len_we,
  input  logic          auto_we,
  input  logic [AW-1:0] addr_data,
  input  logic [LW-1:0] len_data,
  input  logic          auto_data,
  input  logic          start,
  input  logic          keepon,
  input  logic          unmasked,
  input  logic          word_done,
  output logic          en,
  output logic          stall,
  output logic          buf_end,
  output logic          auto_mode,
  output logic [AW-1:0] src_base,
  output logic [AW-1:0] dst_base,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [LW-1:0] len
);
  logic [LW-1:0] idx;
  logic          last;

  assign last    = last_word(32'(idx), 32'(len));
  assign buf_end = word_done & last;
  // Addresses are always base + offset, so each buffer restarts at the bases.
  assign cur_src = src_base + AW'(idx);
  assign cur_dst = dst_base + AW'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base  <= '0;
      dst_base  <= '0;
      len       <= '0;
      auto_mode <= 1'b0;
      en        <= 1'b0;
      stall     <= 1'b0;
      idx       <= '0;
    end else begin
      if (src_we)  src_base  <= addr_data;
      if (dst_we)  dst_base  <= addr_data;
      if (len_we)  len       <= len_data;
      if (auto_we) auto_mode <= auto_data;
      if (keepon)  stall     <= 1'b0;
      if (start && !en) begin
        en    <= 1'b1;
        idx   <= '0;
        stall <= 1'b0;
      end else if (word_done) begin
        if (last) begin
          idx <= '0;
          if (!auto_mode)    en    <= 1'b0;
          else if (unmasked) stall <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmac_mover.sv
module dmac_mover
  import dmac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*AW-1:0] src_flat,
  input  logic [NCH*AW-1:0] dst_flat,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  output logic [NCH-1:0]    word_done
);
  mv_state_e      state;
  logic [NCH-1:0] gnt, sel_q;
  logic [AW-1:0]  src_pick, dst_pick, src_q, dst_q;
  logic [DW-1:0]  data_q;

  dmac_arb #(.N(NCH)) u_arb (.req(req), .gnt(gnt));

  always_comb begin
    src_pick = '0;
    dst_pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        src_pick |= src_flat[i*AW +: AW];
        dst_pick |= dst_flat[i*AW +: AW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      sel_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        MV_IDLE: if (|req) begin
          sel_q <= gnt;
          src_q <= src_pick;
          dst_q <= dst_pick;
          state <= MV_RD;
        end
        MV_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          state  <= MV_WR;
        end
        MV_WR: if (mem_ready) state <= MV_IDLE;
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign mem_valid = (state != MV_IDLE);
  assign mem_write = (state == MV_WR);
  assign mem_addr  = mem_write ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign word_done = (state == MV_WR && mem_ready) ? sel_q : '0;
endmodule

// File: rtl/multibuf_dma.sv
module multibuf_dma
  import dmac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LW  = 8,
  localparam int RAW = $clog2(REG_CFG_BASE + CFG_STRIDE * NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic            irq,
  output logic [NCH-1:0]  stat_en,
  output logic [NCH-1:0]  stat_stall
);
  logic [31:0]       addr_ext;
  logic [NCH-1:0]    ch_en, ch_stall, ch_req, buf_end, word_done, auto_q;
  logic [NCH-1:0]    start_v, keepon_v, mask_q, pend_q, pend_clr;
  logic [NCH*AW-1:0] src_flat, dst_flat;
  logic [AW-1:0]     src_arr [NCH];
  logic [AW-1:0]     dst_arr [NCH];
  logic [LW-1:0]     len_arr [NCH];
  logic              unused_wdata;

  assign addr_ext     = 32'(reg_addr);
  assign unused_wdata = ^reg_wdata;
  assign start_v  = (reg_we && addr_ext == 32'(REG_ENABLE)) ? reg_wdata[NCH-1:0] : '0;
  assign keepon_v = (reg_we && addr_ext == 32'(REG_KEEPON)) ? reg_wdata[NCH-1:0] : '0;
  assign pend_clr = (reg_re && addr_ext == 32'(REG_PEND)) ? pend_q : '0;
  assign ch_req   = ch_en & ~ch_stall;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] cur_src, cur_dst;
    dmac_chan #(.AW(AW), .LW(LW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_we    (reg_we && addr_ext == cfg_addr(g, CFG_SRC)),
      .dst_we    (reg_we && addr_ext == cfg_addr(g, CFG_DST)),
      .len_we    (reg_we && addr_ext == cfg_addr(g, CFG_LEN)),
      .auto_we   (reg_we && addr_ext == cfg_addr(g, CFG_AUTO)),
      .addr_data (reg_wdata[AW-1:0]),
      .len_data  (reg_wdata[LW-1:0]),
      .auto_data (reg_wdata[0]),
      .start     (start_v[g]),
      .keepon    (keepon_v[g]),
      .unmasked  (mask_q[g]),
      .word_done (word_done[g]),
      .en        (ch_en[g]),
      .stall     (ch_stall[g]),
      .buf_end   (buf_end[g]),
      .auto_mode (auto_q[g]),
      .src_base  (src_arr[g]),
      .dst_base  (dst_arr[g]),
      .cur_src   (cur_src),
      .cur_dst   (cur_dst),
      .len       (len_arr[g])
    );
    assign src_flat[g*AW +: AW] = cur_src;
    assign dst_flat[g*AW +: AW] = cur_dst;
  end

  dmac_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (ch_req),
    .src_flat  (src_flat),
    .dst_flat  (dst_flat),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .word_done (word_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (reg_we && addr_ext == 32'(REG_MASK)) mask_q <= reg_wdata[NCH-1:0];
      // A new buffer end wins over a clearing read in the same cycle.
      pend_q <= (pend_q & ~pend_clr) | buf_end;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_ext == 32'(REG_ENABLE)) reg_rdata[2*NCH-1:0] = {ch_stall, ch_en};
    else if (addr_ext == 32'(REG_MASK)) reg_rdata[NCH-1:0] = mask_q;
    else if (addr_ext == 32'(REG_PEND)) reg_rdata[NCH-1:0] = pend_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr_ext == cfg_addr(i, CFG_SRC))  reg_rdata[AW-1:0] = src_arr[i];
      if (addr_ext == cfg_addr(i, CFG_DST))  reg_rdata[AW-1:0] = dst_arr[i];
      if (addr_ext == cfg_addr(i, CFG_LEN))  reg_rdata[LW-1:0] = len_arr[i];
      if (addr_ext == cfg_addr(i, CFG_AUTO)) reg_rdata[0]      = auto_q[i];
    end
  end

  assign irq        = |(pend_q & mask_q);
  assign stat_en    = ch_en;
  assign stat_stall = ch_stall;
endmodule

// File: rtl/multibuf_dma_chk.sv
module multibuf_dma_chk #(
  parameter int NCH = 2,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_valid,
  input logic           mem_write,
  input logic           mem_ready,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] stat_en,
  input logic [NCH-1:0] stat_stall,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] auto_q,
  input logic [NCH-1:0] buf_end,
  input logic [NCH-1:0] word_done
);
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  p_read_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !mem_write);

  p_idle_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_ready |=> !mem_valid);

  p_one_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_done));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_en_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_en[n]) |-> $past(buf_end[n] && !auto_q[n]));

    p_stall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_stall[n]) |-> $past(buf_end[n] && mask_q[n] && auto_q[n]));

    p_no_word_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      word_done[n] |-> stat_en[n] && !stat_stall[n]);

    p_masked_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_end[n] && !mask_q[n] |=> !stat_stall[n]);

    p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_end[n] |=> pend_q[n]);
  end
endmodule

bind multibuf_dma multibuf_dma_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_valid  (mem_valid),
  .mem_write  (mem_write),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .stat_en    (stat_en),
  .stat_stall (stat_stall),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .auto_q     (auto_q),
  .buf_end    (buf_end),
  .word_done  (word_done)
);

// File: tb/multibuf_dma_tb.sv
module multibuf_dma_tb;
  localparam int NCH = 2, AW = 16, DW = 32, LW = 8, RAW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_valid, mem_write, mem_ready = 1'b0, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NCH-1:0] stat_en, stat_stall;

  multibuf_dma #(.NCH(NCH), .AW(AW), .DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq),
    .stat_en(stat_en), .stat_stall(stat_stall));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_val(input int i);
    return 32'hC0DE0000 ^ (32'(i) * 32'h00010203 + 32'd17);
  endfunction

  // Memory model
  logic [31:0] bmem [0:255];
  logic [7:0]  lfsr = 8'h5A;
  logic [AW-1:0] first_wr = '0;
  bit arm = 1'b0;
  assign mem_rdata = bmem[mem_addr[7:0]];

  initial for (int i = 0; i < 256; i++) bmem[i] = seed_val(i);

  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    if (mem_valid && mem_write && mem_ready) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      if (arm) begin first_wr <= mem_addr; arm = 1'b0; end
    end
  end

  // Behavioural reference model
  int m_en[NCH], m_stall[NCH], m_src[NCH], m_dst[NCH], m_len[NCH], m_auto[NCH], m_cnt[NCH];
  logic [NCH-1:0] m_mask = '0, m_pend = '0, en_pre, setp, sets;
  int m_phase = 0, m_sel = 0, wpb, ch, fld;
  logic [31:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_en[i] = 0; m_stall[i] = 0; m_src[i] = 0; m_dst[i] = 0;
        m_len[i] = 0; m_auto[i] = 0; m_cnt[i] = 0;
      end
      m_mask = '0; m_pend = '0; m_phase = 0;
    end else begin
      cyc++;
      setp = '0; sets = '0;
      for (int i = 0; i < NCH; i++) en_pre[i] = (m_en[i] != 0);
      case (m_phase)
        0: begin
          for (int i = NCH - 1; i >= 0; i--)
            if (m_en[i] != 0 && m_stall[i] == 0) begin m_sel = i; m_phase = 1; end
        end
        1: if (mem_ready) begin
          chk(mem_valid && !mem_write, "R10", "read access", {mem_valid, mem_write}, 2'b10);
          chk(mem_addr == AW'(m_src[m_sel] + m_cnt[m_sel]), "R11", "read address",
              mem_addr, AW'(m_src[m_sel] + m_cnt[m_sel]));
          m_data = bmem[8'(m_src[m_sel] + m_cnt[m_sel])];
          m_phase = 2;
        end
        default: if (mem_ready) begin
          chk(mem_valid && mem_write, "R10", "write access", {mem_valid, mem_write}, 2'b11);
          chk(mem_addr == AW'(m_dst[m_sel] + m_cnt[m_sel]), "R2/R3", "write address",
              mem_addr, AW'(m_dst[m_sel] + m_cnt[m_sel]));
          chk(mem_wdata == m_data, "R3", "write data", mem_wdata, m_data);
          wpb = (m_len[m_sel] == 0) ? 1 : m_len[m_sel];
          if (m_cnt[m_sel] + 1 >= wpb) begin
            m_cnt[m_sel] = 0;
            setp[m_sel] = 1'b1;
            if (m_auto[m_sel] == 0) m_en[m_sel] = 0;
            else if (m_mask[m_sel]) begin m_stall[m_sel] = 1; sets[m_sel] = 1'b1; end
          end else m_cnt[m_sel]++;
          m_phase = 0;
        end
      endcase
      if (reg_we) begin
        if (reg_addr == 0) begin
          for (int i = 0; i < NCH; i++)
            if (reg_wdata[i] && !en_pre[i]) begin m_en[i] = 1; m_cnt[i] = 0; m_stall[i] = 0; end
        end else if (reg_addr == 1) begin
          for (int i = 0; i < NCH; i++) if (reg_wdata[i] && !sets[i]) m_stall[i] = 0;
        end else if (reg_addr == 2) m_mask = reg_wdata[NCH-1:0];
        else if (reg_addr >= 4) begin
          ch = (int'(reg_addr) - 4) / 4; fld = (int'(reg_addr) - 4) % 4;
          if (ch < NCH) case (fld)
            0: m_src[ch] = int'(reg_wdata[AW-1:0]);
            1: m_dst[ch] = int'(reg_wdata[AW-1:0]);
            2: m_len[ch] = int'(reg_wdata[LW-1:0]);
            default: m_auto[ch] = int'(reg_wdata[0]);
          endcase
        end
      end
      if (reg_re && reg_addr == 3) m_pend = '0;
      m_pend |= setp;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NCH-1:0] ve, vs;
      for (int i = 0; i < NCH; i++) begin ve[i] = (m_en[i] != 0); vs[i] = (m_stall[i] != 0); end
      chk(stat_en == ve, "R2", "enable flags", stat_en, ve);
      chk(stat_stall == vs, "R5", "stall flags", stat_stall, vs);
      chk(irq == |(m_pend & m_mask), "R9", "irq", irq, |(m_pend & m_mask));
      chk(mem_valid == (m_phase != 0), "R10", "mem_valid", mem_valid, m_phase != 0);
    end
  end

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = RAW'(a);
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_en(input int c, input logic v);
    while (stat_en[c] !== v) @(negedge clk);
  endtask

  task automatic wait_stall(input int c);
    while (stat_stall[c] !== 1'b1) @(negedge clk);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(stat_en == 0 && stat_stall == 0, "R1", "flags after reset", {stat_stall, stat_en}, 0);
    chk(irq == 0 && mem_valid == 0, "R1", "irq/valid after reset", {irq, mem_valid}, 0);
    reg_rd(3, rd);
    chk(rd == 0, "R1", "pending after reset", rd, 0);

    // Channel 0: unmasked, auto reload, three buffers of three words
    reg_wr(4, 32'h10); reg_wr(5, 32'h80); reg_wr(6, 3); reg_wr(7, 1);
    reg_wr(2, 32'h1);
    reg_wr(0, 32'h1);
    wait_stall(0);
    chk(stat_en[0] == 1, "R2", "enable held during stall", stat_en[0], 1);
    chk(irq == 1, "R9", "irq on unmasked buffer end", irq, 1);
    reg_rd(0, rd);
    chk(rd == 32'h5, "R12", "status readback", rd, 32'h5);
    reg_rd(3, rd);
    chk(rd == 32'h1, "R9", "pending read", rd, 1);
    chk(irq == 0, "R9", "irq after clearing read", irq, 0);
    repeat (10) @(negedge clk);
    chk(mem_valid == 0 && stat_stall[0] == 1, "R5", "no access while stalled",
        {mem_valid, stat_stall[0]}, 2'b01);
    for (int k = 0; k < 3; k++)
      chk(bmem[8'h80 + k] == seed_val(8'h10 + k), "R3", "first buffer copy",
          bmem[8'h80 + k], seed_val(8'h10 + k));
    reg_wr(1, 32'h2);
    chk(stat_stall == 2'b01, "R6", "keep-on to idle channel ignored", stat_stall, 2'b01);
    reg_wr(1, 32'h1);
    chk(stat_stall[0] == 0, "R6", "keep-on releases stall", stat_stall[0], 0);
    wait_stall(0);
    reg_wr(7, 0);
    reg_wr(1, 32'h1);
    wait_en(0, 1'b0);
    chk(irq == 1, "R4", "last buffer end flagged", irq, 1);
    chk(bmem[8'h83] == seed_val(8'h83), "R3", "reload keeps buffer in place",
        bmem[8'h83], seed_val(8'h83));
    reg_rd(3, rd);

    // Channel 1: masked, zero count, auto reload
    reg_wr(2, 0);
    reg_wr(8, 32'h30); reg_wr(9, 32'hB0); reg_wr(10, 0); reg_wr(11, 1);
    reg_wr(0, 32'h2);
    repeat (40) @(negedge clk);
    chk(stat_en[1] == 1 && stat_stall[1] == 0, "R7", "masked channel keeps running",
        {stat_en[1], stat_stall[1]}, 2'b10);
    reg_wr(11, 0);
    wait_en(1, 1'b0);
    chk(bmem[8'hB0] == seed_val(8'h30), "R8", "one-word buffer copy", bmem[8'hB0], seed_val(8'h30));
    chk(bmem[8'hB1] == seed_val(8'hB1), "R8", "only one word per buffer", bmem[8'hB1], seed_val(8'hB1));
    chk(irq == 0, "R9", "masked pending gives no irq", irq, 0);
    reg_rd(3, rd);
    chk(rd == 32'h2, "R9", "masked pending readable", rd, 32'h2);

    // Both channels started together, single buffer each
    reg_wr(4, 32'h40); reg_wr(5, 32'hC0); reg_wr(6, 4); reg_wr(7, 0);
    reg_wr(8, 32'h50); reg_wr(9, 32'hD0); reg_wr(10, 2);
    arm = 1'b1;
    reg_wr(0, 32'h3);
    repeat (5) @(negedge clk);
    reg_wr(0, 32'h1);
    wait_en(0, 1'b0);
    wait_en(1, 1'b0);
    chk(first_wr == AW'(16'hC0), "R11", "lowest channel served first", first_wr, 16'hC0);
    for (int k = 0; k < 4; k++)
      chk(bmem[8'hC0 + k] == seed_val(8'h40 + k), "R4", "channel 0 single buffer",
          bmem[8'hC0 + k], seed_val(8'h40 + k));
    for (int k = 0; k < 2; k++)
      chk(bmem[8'hD0 + k] == seed_val(8'h50 + k), "R3", "channel 1 single buffer",
          bmem[8'hD0 + k], seed_val(8'h50 + k));
    reg_rd(8, rd);
    chk(rd == 32'h50, "R12", "source base readback", rd, 32'h50);
    reg_rd(6, rd);
    chk(rd == 32'h4, "R12", "count readback", rd, 32'h4);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule